// File: doc/BRIEF.md
# Four-Rail Power Sequencer with Fault Monitor

This block brings up and takes down four supply rails that feed a group of programmable logic devices. Software on a byte-wide register bus sets one request bit. The block then switches the rails on one at a time, and each rail waits for its own power-good input before the next one starts. The request bit is read back exactly as it was written. A status byte shows the live power-good inputs and the alarm input. A failure byte keeps a record of what went wrong.

Clearing the request takes the rails down in reverse order, one rail per clock. After that comes a discharge interval of fixed length, and no rail may switch on during it, even if a new request is already waiting. This rule stops a fast off/on toggle from leaving the ramp waiting on power-goods that never come. The block shuts the rails down at once, and clears the request, in these cases:
- a rail misses its power-good window;
- a power-good input drops while all rails are up;
- the alarm input asserts.

The timeout window and the discharge interval are parameters counted in clock cycles.

Top module: `pwrseq_mon`

## Requirements
- R1: The identity byte at address 0x2000 reads 0x03. Any address other than 0x2000, 0x2006, 0x200A and 0x200B reads 0x00. A write to any address other than 0x2006 has no effect on the rails or on any register.
- R2: Bit 0 of the control byte at 0x2006 is the power request. Reading 0x2006 returns {7'b0, request}.
- R3: The rails switch on strictly in the order 0, 1, 2, 3, one rail at a time. Rail k (k>0) is enabled only in the cycle after power-good k-1 was seen high. Once all four power-goods are high, all four enables stay on.
- R4: The status byte at 0x200A reads {3'b0, alarm, pgood[3:0]} from the live inputs. Full power corresponds to the value 0x0F.
- R5: During ramp-up, suppose the power-good of the rail being enabled is not seen within TMO_CYC cycles. The failure byte then gains the one-hot bit of that rail (bit k for rail k), and shutdown starts.
- R6: Shutdown turns the enables off from the highest enabled rail downward, one rail per cycle. After the last rail goes off, the enables stay all zero for at least BLEED_CYC cycles, whatever the request.
- R7: The failure byte at 0x200B accumulates fault bits. It clears only when a write to 0x2006 sets bit 0 while the request was 0. Writing 0 to the control byte, or writing other addresses, leaves it unchanged.
- R8: With all rails up, suppose any power-good input goes low. The failure byte then gains the one-hot bit of the lowest rail that is low, and shutdown starts.
- R9: The alarm input high during ramp-up or full power sets failure bit 4 and starts shutdown. All four enables do not stay on in the following cycle.
- R10: A shutdown caused by R5, R8 or R9 clears the request bit. The rails stay off until a new request is written.
- R11: At the end of the discharge interval, any power-good still high sets failure bit 5, and the alarm high sets failure bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pgood | input | 4 | Power-good input per rail |
| alarm | input | 1 | Over-current / over-temperature alarm |
| rail_en | output | 4 | Enable output per rail |

## Verification
A bench model of the supplies returns each power-good two cycles after its enable. A clean ramp then shows the one-rail-at-a-time order. A ramp with rail 2 held dead exercises the timeout and checks that the one-hot code names that rail. A rail pulled low at full power is told apart from the alarm by the failure code: bit 1 for the rail, bit 4 for the alarm. A re-request written during shutdown shows that discharge lockout holds the enables low. A power-good held high after shutdown is the only pattern that reaches failure bit 5.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int unsigned NRAIL = 4;

  localparam logic [15:0] ADDR_ID    = 16'h2000;
  localparam logic [15:0] ADDR_CTRL  = 16'h2006;
  localparam logic [15:0] ADDR_STAT  = 16'h200A;
  localparam logic [15:0] ADDR_FAULT = 16'h200B;
  localparam logic [7:0]  ID_VALUE   = 8'h03;

  localparam int unsigned FB_ALARM = 4;
  localparam int unsigned FB_STUCK = 5;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_RAMP,
    PS_RUN,
    PS_DROP,
    PS_BLEED
  } pseq_state_e;

  // enables for a given number of active rails (thermometer code)
  function automatic logic [NRAIL-1:0] rails_for_level(input logic [2:0] lvl);
    logic [NRAIL-1:0] m;
    for (int i = 0; i < NRAIL; i++) m[i] = (3'(i) < lvl);
    return m;
  endfunction

  // one-hot select of the rail most recently switched on
  function automatic logic [NRAIL-1:0] top_rail(input logic [2:0] lvl);
    logic [NRAIL-1:0] m;
    for (int i = 0; i < NRAIL; i++) m[i] = (3'(i + 1) == lvl);
    return m;
  endfunction

  // one-hot of the lowest rail whose power-good is low
  function automatic logic [NRAIL-1:0] lowest_low(input logic [NRAIL-1:0] pg);
    logic [NRAIL-1:0] m;
    m = '0;
    for (int i = NRAIL - 1; i >= 0; i--) begin
      if (!pg[i]) m = NRAIL'(1) << i;
    end
    return m;
  endfunction

endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  input  logic [NRAIL-1:0] pgood,
  input  logic             alarm,
  input  logic [7:0]       fail_q,
  input  logic             fault_stop,
  output logic             req_q,
  output logic             new_req,
  output logic [7:0]       bus_rdata
);

  logic ctrl_wr;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign new_req = ctrl_wr && bus_wdata[0] && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          req_q <= 1'b0;
    else if (fault_stop) req_q <= 1'b0;
    else if (ctrl_wr)    req_q <= bus_wdata[0];
  end

  always_comb begin
    case (bus_addr)
      ADDR_ID:    bus_rdata = ID_VALUE;
      ADDR_CTRL:  bus_rdata = {7'b0, req_q};
      ADDR_STAT:  bus_rdata = {3'b0, alarm, pgood};
      ADDR_FAULT: bus_rdata = fail_q;
      default:    bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int unsigned TMO_CYC   = 100_000_000,
  parameter int unsigned BLEED_CYC = 50_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_q,
  input  logic             new_req,
  input  logic [NRAIL-1:0] pgood,
  input  logic             alarm,
  output logic [NRAIL-1:0] rail_en,
  output logic             fault_stop,
  output logic [7:0]       fail_q
);

  localparam int unsigned CMAX = (TMO_CYC > BLEED_CYC) ? TMO_CYC : BLEED_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] TMO_LAST   = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] BLEED_LAST = CW'(BLEED_CYC - 1);

  pseq_state_e      st_q, st_d;
  logic [2:0]       lvl_q, lvl_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [7:0]       code;
  logic [NRAIL-1:0] cur_rail;
  logic             cur_good;
  logic             all_good;

  assign cur_rail = top_rail(lvl_q);
  assign cur_good = |(pgood & cur_rail);
  assign all_good = &pgood;
  assign rail_en  = rails_for_level(lvl_q);

  always_comb begin
    st_d       = st_q;
    lvl_d      = lvl_q;
    cnt_d      = cnt_q;
    code       = '0;
    fault_stop = 1'b0;
    case (st_q)
      PS_OFF: begin
        if (req_q) begin
          st_d  = PS_RAMP;
          lvl_d = 3'd1;
          cnt_d = '0;
        end
      end
      PS_RAMP: begin
        if (alarm) begin
          code[FB_ALARM] = 1'b1;
          fault_stop     = 1'b1;
          st_d           = PS_DROP;
          lvl_d          = lvl_q - 3'd1;
        end else if (!req_q) begin
          st_d  = PS_DROP;
          lvl_d = lvl_q - 3'd1;
        end else if (cur_good) begin
          cnt_d = '0;
          if (lvl_q == 3'(NRAIL)) st_d = PS_RUN;
          else                    lvl_d = lvl_q + 3'd1;
        end else if (cnt_q == TMO_LAST) begin
          code[NRAIL-1:0] = cur_rail;
          fault_stop      = 1'b1;
          st_d            = PS_DROP;
          lvl_d           = lvl_q - 3'd1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PS_RUN: begin
        if (alarm || !all_good) begin
          code[FB_ALARM]  = alarm;
          code[NRAIL-1:0] = lowest_low(pgood);
          fault_stop      = 1'b1;
          st_d            = PS_DROP;
          lvl_d           = lvl_q - 3'd1;
        end else if (!req_q) begin
          st_d  = PS_DROP;
          lvl_d = lvl_q - 3'd1;
        end
      end
      PS_DROP: begin
        if (lvl_q == 3'd0) begin
          st_d  = PS_BLEED;
          cnt_d = '0;
        end else begin
          lvl_d = lvl_q - 3'd1;
        end
      end
      PS_BLEED: begin
        if (cnt_q == BLEED_LAST) begin
          code[FB_STUCK] = |pgood;
          code[FB_ALARM] = alarm;
          st_d           = PS_OFF;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PS_OFF;
      lvl_q  <= '0;
      cnt_q  <= '0;
      fail_q <= '0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      fail_q <= (new_req ? 8'h00 : fail_q) | code;
    end
  end

endmodule

// File: rtl/pwrseq_mon.sv
module pwrseq_mon
  import pwrseq_pkg::*;
#(
  parameter int unsigned TMO_CYC   = 100_000_000,
  parameter int unsigned BLEED_CYC = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [3:0]  pgood,
  input  logic        alarm,
  output logic [3:0]  rail_en
);

  logic       req_q;
  logic       new_req;
  logic       fault_stop;
  logic [7:0] fail_q;

  pwrseq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .pgood      (pgood),
    .alarm      (alarm),
    .fail_q     (fail_q),
    .fault_stop (fault_stop),
    .req_q      (req_q),
    .new_req    (new_req),
    .bus_rdata  (bus_rdata)
  );

  pwrseq_fsm #(
    .TMO_CYC   (TMO_CYC),
    .BLEED_CYC (BLEED_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_q      (req_q),
    .new_req    (new_req),
    .pgood      (pgood),
    .alarm      (alarm),
    .rail_en    (rail_en),
    .fault_stop (fault_stop),
    .fail_q     (fail_q)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int unsigned BLEED_CYC = 50_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rail_en,
  input logic [3:0] pgood,
  input logic       alarm,
  input logic       req_q,
  input logic       new_req,
  input logic       fault_stop,
  input logic [7:0] fail_q
);

  localparam int unsigned ZW = $clog2(BLEED_CYC + 1);

  logic [ZW-1:0] off_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                                 off_run <= ZW'(BLEED_CYC);
    else if (rail_en != 4'h0)                   off_run <= '0;
    else if (off_run < ZW'(BLEED_CYC))          off_run <= off_run + 1'b1;
  end

  AST_ONE_RAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en ^ $past(rail_en)) <= 1); // R6

  for (genvar i = 1; i < 4; i++) begin : g_order
    AST_ORDERED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en[i]) |-> $past(pgood[i-1])); // R3
  end

  AST_DISCHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|rail_en) |-> (off_run >= ZW'(BLEED_CYC))); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !new_req |=> ((fail_q & $past(fail_q)) == $past(fail_q))); // R7

  AST_ALARM_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && rail_en == 4'hF) |=> (rail_en != 4'hF)); // R9

  AST_FAULT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stop |=> !req_q); // R10

endmodule

bind pwrseq_mon pwrseq_chk #(.BLEED_CYC(BLEED_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rail_en    (rail_en),
  .pgood      (pgood),
  .alarm      (alarm),
  .req_q      (req_q),
  .new_req    (new_req),
  .fault_stop (fault_stop),
  .fail_q     (fail_q)
);

// File: tb/sim_pwrseq_mon.sv
module sim_pwrseq_mon;

  localparam int TMO = 20;
  localparam int BL  = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic [3:0]  pgood = 4'h0;
  logic        alarm = 1'b0;
  logic [3:0]  rail_en;

  logic [3:0]  d1 = 4'h0, kill = 4'h0, stuck = 4'h0;
  int nvec = 0, nfail = 0;
  bit done = 0;

  // reference model state
  int m_st = 0, m_lvl = 0, m_cnt = 0;
  bit m_req = 0;
  int m_fail = 0;

  always #5 clk = ~clk;

  pwrseq_mon #(.TMO_CYC(TMO), .BLEED_CYC(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pgood(pgood),
    .alarm(alarm), .rail_en(rail_en)
  );

  // supply model: power-good follows enable by two cycles
  always @(negedge clk) begin
    #1;
    pgood <= (d1 & ~kill) | stuck;
    d1    <= rail_en;
  end

  // behavioural reference, states: 0 off, 1 ramp, 2 run, 3 drop, 4 bleed
  always @(posedge clk) begin
    int code;
    bit stop, nreq;
    code = 0;
    stop = 0;
    if (!rst_n) begin
      m_st = 0; m_lvl = 0; m_cnt = 0; m_req = 0; m_fail = 0;
    end else begin
      nreq = bus_wr && bus_addr == 16'h2006 && bus_wdata[0] && !m_req;
      case (m_st)
        0: if (m_req) begin m_st = 1; m_lvl = 1; m_cnt = 0; end
        1: begin
          if (alarm) begin code = 16; stop = 1; m_st = 3; m_lvl--; end
          else if (!m_req) begin m_st = 3; m_lvl--; end
          else if (pgood[m_lvl-1]) begin
            m_cnt = 0;
            if (m_lvl == 4) m_st = 2; else m_lvl++;
          end else if (m_cnt == TMO - 1) begin
            code = 1 << (m_lvl - 1); stop = 1; m_st = 3; m_lvl--;
          end else m_cnt++;
        end
        2: begin
          if (alarm || pgood != 4'hF) begin
            if (alarm) code |= 16;
            for (int i = 3; i >= 0; i--) if (!pgood[i]) code = (code & 16) | (1 << i);
            stop = 1; m_st = 3; m_lvl--;
          end else if (!m_req) begin m_st = 3; m_lvl--; end
        end
        3: if (m_lvl == 0) begin m_st = 4; m_cnt = 0; end else m_lvl--;
        default: begin
          if (m_cnt == BL - 1) begin
            if (pgood != 0) code |= 32;
            if (alarm) code |= 16;
            m_st = 0;
          end else m_cnt++;
        end
      endcase
      m_fail = (nreq ? 0 : m_fail) | code;
      if (stop) m_req = 0;
      else if (bus_wr && bus_addr == 16'h2006) m_req = bus_wdata[0];
    end
  end

  function automatic int exp_rd(input logic [15:0] a);
    case (a)
      16'h2000: return 3;
      16'h2006: return int'(m_req);
      16'h200A: return {alarm, pgood};
      16'h200B: return m_fail;
      default:  return 0;
    endcase
  endfunction

  // compare against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      nvec++;
      if (rail_en !== 4'((1 << m_lvl) - 1)) begin
        nfail++;
        $display("FAIL R3/R6 model rail_en act=%h exp=%h t=%0t", rail_en, 4'((1 << m_lvl) - 1), $time);
      end
      nvec++;
      if (bus_rdata !== 8'(exp_rd(bus_addr))) begin
        nfail++;
        $display("FAIL R1/R2 model rdata@%h act=%h exp=%h t=%0t", bus_addr, bus_rdata, exp_rd(bus_addr), $time);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output int v);
    bus_addr = a;
    #2;
    v = bus_rdata;
  endtask

  task automatic wait_en(input logic [3:0] v, input int maxc, input string tag);
    for (int i = 0; i < maxc && rail_en !== v; i++) @(negedge clk);
    #1;
    chk(rail_en === v, tag, rail_en, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  int v;

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // reset state
    rd(16'h2000, v); chk(v == 3, "R1 id", v, 3);
    rd(16'h2006, v); chk(v == 0, "R2 ctrl reset", v, 0);
    rd(16'h200B, v); chk(v == 0, "R7 fail reset", v, 0);
    chk(rail_en == 0, "R3 rails reset", rail_en, 0);

    // clean ramp
    wr(16'h2006, 8'h01);
    rd(16'h2006, v); chk(v == 1, "R2 readback", v, 1);
    for (int i = 0; i < 10 && rail_en == 0; i++) @(negedge clk);
    #1;
    chk(rail_en == 4'h1, "R3 first rail", rail_en, 1);
    wait_en(4'hF, 40, "R3 all rails");
    idle(4);
    rd(16'h200A, v); chk(v == 8'h0F, "R4 status good", v, 8'h0F);

    // ignored writes
    wr(16'h2000, 8'h55);
    wr(16'h2010, 8'hFF);
    rd(16'h2000, v); chk(v == 3, "R1 id after write", v, 3);
    rd(16'h2010, v); chk(v == 0, "R1 unmapped", v, 0);
    chk(rail_en == 4'hF, "R1 rails unaffected", rail_en, 4'hF);

    // reverse shutdown then immediate re-request during discharge
    wr(16'h2006, 8'h00);
    @(negedge clk); chk(rail_en == 4'h7, "R6 drop rail3", rail_en, 7);
    @(negedge clk); chk(rail_en == 4'h3, "R6 drop rail2", rail_en, 3);
    @(negedge clk); chk(rail_en == 4'h1, "R6 drop rail1", rail_en, 1);
    @(negedge clk); chk(rail_en == 4'h0, "R6 drop rail0", rail_en, 0);
    #1;
    wr(16'h2006, 8'h01);
    for (int i = 0; i < BL - 3; i++) begin
      @(negedge clk);
      chk(rail_en == 4'h0, "R6 lockout", rail_en, 0);
    end
    #1;
    wait_en(4'hF, 60, "R6 ramp after lockout");

    // timeout on rail 2
    wr(16'h2006, 8'h00);
    idle(BL + 10);
    kill = 4'b0100;
    wr(16'h2006, 8'h01);
    wait_en(4'h7, 30, "R5 reach rail2");
    wait_en(4'h0, TMO + 10, "R5 shutdown");
    rd(16'h200B, v); chk(v == 8'h04, "R5 timeout code", v, 4);
    rd(16'h2006, v); chk(v == 0, "R10 request cleared", v, 0);
    idle(BL + 10);
    chk(rail_en == 0, "R10 stays off", rail_en, 0);
    kill = 4'h0;

    // new request clears the failure byte
    wr(16'h2006, 8'h01);
    rd(16'h200B, v); chk(v == 0, "R7 cleared by request", v, 0);
    wait_en(4'hF, 40, "R3 ramp again");
    idle(3);

    // rail 1 drops at full power
    kill = 4'b0010;
    wait_en(4'h0, 20, "R8 shutdown");
    kill = 4'h0;
    rd(16'h200B, v); chk(v == 8'h02, "R8 drop code", v, 2);
    rd(16'h2006, v); chk(v == 0, "R10 request cleared drop", v, 0);
    wr(16'h2006, 8'h00);
    wr(16'h200B, 8'h00);
    rd(16'h200B, v); chk(v == 8'h02, "R7 sticky", v, 2);
    idle(BL + 10);

    // alarm at full power
    wr(16'h2006, 8'h01);
    wait_en(4'hF, 40, "R9 ramp");
    idle(3);
    alarm = 1'b1;
    rd(16'h200A, v); chk((v & 8'h10) == 8'h10, "R4 alarm bit", v, 8'h10);
    @(negedge clk); #1;
    chk(rail_en != 4'hF, "R9 immediate shutdown", rail_en, 7);
    wait_en(4'h0, 10, "R9 rails off");
    alarm = 1'b0;
    rd(16'h200B, v); chk(v == 8'h10, "R9 alarm code", v, 8'h10);
    idle(BL + 10);

    // power-good stuck after shutdown
    wr(16'h2006, 8'h01);
    wait_en(4'hF, 40, "R11 ramp");
    idle(3);
    stuck = 4'b1000;
    wr(16'h2006, 8'h00);
    idle(BL + 12);
    rd(16'h200B, v); chk(v == 8'h20, "R11 stuck code", v, 8'h20);
    rd(16'h200A, v); chk(v == 8'h08, "R4 stuck status", v, 8'h08);
    stuck = 4'h0;
    idle(5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule